// File: doc/BRIEF.md
# Protected Register Write Unlock

This block shields two critical 8-bit control registers, one for clock control and one for flash programming mode, from stray stores caused by runaway software. A store to either of them takes effect only when the bus write directly before it went to a dedicated command register. The code written to the command register can be any byte; only the fact of the write matters. A protected store that breaks this sequence is dropped, and a sticky error bit in a status register records it.

The block sits on a simple synchronous byte-wide register bus. A write takes one cycle with `we_i` high. Read data is a combinational function of `addr_i`. Cycles with `we_i` low never change the unlock state. The two protected registers drive their values straight out to the logic they control.

Top module: `prot_wr_unlock`

## Requirements
- R1: After reset the clock control register (offset 0x808) and the flash mode register (offset 0x809) hold their reset values, 0x00 by default. The error flag reads 0 and the block is locked.
- R2: A write of any byte to the command register (offset 0x800), followed directly by a write to a protected register, loads that write's data into the register.
- R3: A write to a protected register whose preceding bus write did not go to the command register is discarded, and the register keeps its value.
- R4: A discarded protected write sets the error flag, which is bit 0 of the status register (offset 0x801). Bits 7:1 of the status register read 0.
- R5: The error flag is sticky. A status write with bit 0 = 0 clears it. A status write with bit 0 = 1 and accepted protected writes leave it unchanged.
- R6: The unlock is used up by the next bus write, whatever its address. If that write goes to a status, unmapped or other non-protected address, the block is locked again.
- R7: Cycles with `we_i` low, at any address, neither use up nor cancel a pending unlock.
- R8: Reads return the protected registers and the status register at their offsets. The command register and unmapped offsets read 0x00.
- R9: One unlock allows exactly one protected write. A second protected write right after an accepted one is discarded and sets the error flag.
- R10: Writing the command register while already unlocked keeps the block unlocked for the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register offset within the I/O page |
| we_i | input | 1 | Write strobe, one write per cycle |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| clk_ctrl_o | output | 8 | Current clock control register value |
| flash_mode_o | output | 8 | Current flash mode register value |
| prot_err_o | output | 1 | Sticky protection error flag |

## Verification
The bench sweeps all 256 command codes so that a design that compares the code against a key rejects legal sequences. It sweeps locked stores to both targets so that a missing guard corrupts a register or leaves the error flag clear. Directed sequences place a status write, an unmapped write, or a second protected write between unlock and target. A design that only clears its unlock on protected writes would then accept a store it must drop. Idle cycles at varied addresses catch a design that treats a read as a bus access. A long pseudo-random run, compared against an arithmetic model, covers back-to-back command writes and status writes with bit 0 = 1. A wrong sticky flag shows up there.

// File: rtl/prwu_pkg.sv
package prwu_pkg;
  localparam int DATA_W    = 8;
  localparam int NUM_PROT  = 2;
  localparam int IDX_CLK   = 0;
  localparam int IDX_FLASH = 1;

  typedef logic [DATA_W-1:0] byte_t;

  typedef struct packed {
    logic                cmd;
    logic                stat;
    logic [NUM_PROT-1:0] prot;
  } hit_t;
endpackage

// File: rtl/prwu_addr_dec.sv
module prwu_addr_dec
  import prwu_pkg::*;
#(
  parameter int               ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 12'h800,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h801,
  parameter logic [ADDR_W-1:0] PROT_BASE = 12'h808
) (
  input  logic [ADDR_W-1:0] addr_i,
  output hit_t              hit_o
);
  assign hit_o.cmd  = (addr_i == CMD_ADDR);
  assign hit_o.stat = (addr_i == STAT_ADDR);

  for (genvar i = 0; i < NUM_PROT; i++) begin : g_prot_hit
    localparam logic [ADDR_W-1:0] SLOT = PROT_BASE + ADDR_W'(i);
    assign hit_o.prot[i] = (addr_i == SLOT);
  end
endmodule

// File: rtl/prwu_unlock_ctrl.sv
module prwu_unlock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic hit_cmd_i,
  input  logic hit_prot_i,
  output logic unlock_o,
  output logic grant_o,
  output logic viol_o
);
  logic unlock_q;

  // any write re-arms or drops the unlock; idle cycles hold it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   unlock_q <= 1'b0;
    else if (we_i) unlock_q <= hit_cmd_i;
  end

  assign unlock_o = unlock_q;
  assign grant_o  = we_i && hit_prot_i && unlock_q;
  assign viol_o   = we_i && hit_prot_i && !unlock_q;

  a_r2_cmd_arms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit_cmd_i) |=> unlock_o);
  a_r6_write_consumes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hit_cmd_i) |=> !unlock_o);
  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(unlock_o));
  a_r9_one_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);
endmodule

// File: rtl/prwu_err_flag.sv
module prwu_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic viol_i,
  input  logic stat_wr_i,
  input  logic stat_bit_i,
  output logic err_o
);
  logic err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      err_q <= 1'b0;
    else if (viol_i)                  err_q <= 1'b1;
    else if (stat_wr_i && !stat_bit_i) err_q <= 1'b0;
  end

  assign err_o = err_q;

  a_r4_viol_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_i |=> err_o);
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !(stat_wr_i && !stat_bit_i)) |=> err_o);
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr_i && !stat_bit_i && !viol_i) |=> !err_o);
endmodule

// File: rtl/prwu_prot_reg.sv
module prwu_prot_reg
  import prwu_pkg::*;
#(
  parameter byte_t RST_VAL = '0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  byte_t wdata_i,
  output byte_t q_o
);
  byte_t q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= RST_VAL;
    else if (wr_i) q <= wdata_i;
  end

  assign q_o = q;
endmodule

// File: rtl/prot_wr_unlock.sv
module prot_wr_unlock
  import prwu_pkg::*;
#(
  parameter int                        ADDR_W    = 12,
  parameter logic [ADDR_W-1:0]         CMD_ADDR  = 12'h800,
  parameter logic [ADDR_W-1:0]         STAT_ADDR = 12'h801,
  parameter logic [ADDR_W-1:0]         PROT_BASE = 12'h808,
  parameter logic [NUM_PROT*DATA_W-1:0] PROT_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [7:0]        clk_ctrl_o,
  output logic [7:0]        flash_mode_o,
  output logic              prot_err_o
);
  hit_t                      hit;
  logic                      unlock, grant, viol, err;
  logic [NUM_PROT-1:0][DATA_W-1:0] prot_q;

  prwu_addr_dec #(
    .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR), .STAT_ADDR(STAT_ADDR), .PROT_BASE(PROT_BASE)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (hit)
  );

  prwu_unlock_ctrl u_unlock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (we_i),
    .hit_cmd_i (hit.cmd),
    .hit_prot_i(|hit.prot),
    .unlock_o  (unlock),
    .grant_o   (grant),
    .viol_o    (viol)
  );

  prwu_err_flag u_err (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .viol_i    (viol),
    .stat_wr_i (we_i && hit.stat),
    .stat_bit_i(wdata_i[0]),
    .err_o     (err)
  );

  for (genvar i = 0; i < NUM_PROT; i++) begin : g_prot
    prwu_prot_reg #(
      .RST_VAL(PROT_RST[i*DATA_W +: DATA_W])
    ) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (grant && hit.prot[i]),
      .wdata_i(wdata_i),
      .q_o    (prot_q[i])
    );

    a_r3_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && hit.prot[i] && !unlock) |=> $stable(prot_q[i]));
    a_r2_unlocked_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && hit.prot[i] && unlock) |=> (prot_q[i] == $past(wdata_i)));
  end

  // command register is write-only and unmapped offsets read zero
  always_comb begin
    rdata_o = '0;
    if (hit.stat) rdata_o[0] = err;
    for (int i = 0; i < NUM_PROT; i++)
      if (hit.prot[i]) rdata_o = prot_q[i];
  end

  assign clk_ctrl_o   = prot_q[IDX_CLK];
  assign flash_mode_o = prot_q[IDX_FLASH];
  assign prot_err_o   = err;

  a_r8_cmd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit.cmd |-> (rdata_o == 8'h00));
  a_r4_stat_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit.stat |-> (rdata_o[7:1] == 7'h00));
endmodule

// File: tb/prot_wr_unlock_tb.sv
module prot_wr_unlock_tb_top;
  localparam logic [11:0] A_CMD   = 12'h800;
  localparam logic [11:0] A_STAT  = 12'h801;
  localparam logic [11:0] A_CLK   = 12'h808;
  localparam logic [11:0] A_FLASH = 12'h809;
  localparam logic [11:0] A_FREE  = 12'h123;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o, clk_ctrl_o, flash_mode_o;
  logic        prot_err_o;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model, derived from requirements
  logic [7:0] m_clk = 8'h00, m_flash = 8'h00;
  bit m_err = 0, m_unl = 0;

  always #2 clk_i = ~clk_i;

  prot_wr_unlock dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .clk_ctrl_o(clk_ctrl_o), .flash_mode_o(flash_mode_o),
    .prot_err_o(prot_err_o)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (a == A_CLK || a == A_FLASH) begin
      if (m_unl) begin
        if (a == A_CLK) m_clk = d; else m_flash = d;
      end else m_err = 1;
    end else if (a == A_STAT && !d[0]) m_err = 0;
    m_unl = (a == A_CMD);
  endtask

  task automatic idle(input logic [11:0] a);
    @(negedge clk_i);
    addr_i = a; wdata_i = 8'hFF; we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic check_all(input string tag);
    logic [7:0] d;
    chk({tag, " clk_o"}, clk_ctrl_o, m_clk);
    chk({tag, " flash_o"}, flash_mode_o, m_flash);
    chk({tag, " err_o"}, {7'b0, prot_err_o}, {7'b0, m_err});
    rd(A_CLK, d);   chk({tag, " rd clk"}, d, m_clk);
    rd(A_FLASH, d); chk({tag, " rd flash"}, d, m_flash);
    rd(A_STAT, d);  chk({tag, " rd stat"}, d, {7'b0, m_err});
  endtask

  initial begin
    logic [7:0] d;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    check_all("R1 reset");
    // R1 locked after reset: first protected write rejected
    wr(A_CLK, 8'h11);
    chk("R1 locked after reset", clk_ctrl_o, 8'h00);
    chk("R1 err after reset write", {7'b0, prot_err_o}, 8'h01);
    wr(A_STAT, 8'h00);
    chk("R5 clear by zero", {7'b0, prot_err_o}, 8'h00);

    // R2 every command code unlocks
    for (int c = 0; c < 256; c++) begin
      wr(A_CMD, 8'(c));
      wr((c % 2) ? A_FLASH : A_CLK, 8'(c) ^ 8'h5A);
      chk("R2 code sweep", (c % 2) ? flash_mode_o : clk_ctrl_o, 8'(c) ^ 8'h5A);
      chk("R5 legal write keeps err 0", {7'b0, prot_err_o}, 8'h00);
    end

    // R3/R4 locked store sweep
    for (int v = 0; v < 256; v++) begin
      wr((v % 2) ? A_CLK : A_FLASH, 8'(v));
      chk("R3 locked clk", clk_ctrl_o, m_clk);
      chk("R3 locked flash", flash_mode_o, m_flash);
      chk("R4 err set", {7'b0, prot_err_o}, 8'h01);
    end
    rd(A_STAT, d); chk("R4 status layout", d, 8'h01);
    wr(A_STAT, 8'h01);
    chk("R5 write one keeps err", {7'b0, prot_err_o}, 8'h01);
    wr(A_CMD, 8'h00); wr(A_CLK, 8'hC3);
    chk("R5 legal write keeps err", {7'b0, prot_err_o}, 8'h01);
    chk("R2 load with err set", clk_ctrl_o, 8'hC3);
    wr(A_STAT, 8'hFE);
    chk("R5 clear by FE", {7'b0, prot_err_o}, 8'h00);

    // R6 consumption by non-protected writes
    wr(A_CMD, 8'h77); wr(A_STAT, 8'h01); wr(A_FLASH, 8'h99);
    chk("R6 status write consumes", flash_mode_o, m_flash);
    chk("R6 err", {7'b0, prot_err_o}, 8'h01);
    wr(A_STAT, 8'h00);
    wr(A_CMD, 8'h77); wr(A_FREE, 8'h00); wr(A_CLK, 8'h99);
    chk("R6 unmapped write consumes", clk_ctrl_o, m_clk);
    chk("R6 err2", {7'b0, prot_err_o}, 8'h01);
    wr(A_STAT, 8'h00);

    // R7 idle cycles keep unlock
    wr(A_CMD, 8'hA5);
    idle(A_CLK); idle(A_FLASH); idle(A_STAT); idle(A_FREE);
    rd(A_CMD, d); chk("R8 cmd reads zero", d, 8'h00);
    wr(A_FLASH, 8'h3C);
    chk("R7 idle keeps unlock", flash_mode_o, 8'h3C);
    chk("R7 no err", {7'b0, prot_err_o}, 8'h00);

    // R9 one write per unlock
    wr(A_CMD, 8'h01); wr(A_CLK, 8'h42); wr(A_FLASH, 8'h24);
    chk("R9 first accepted", clk_ctrl_o, 8'h42);
    chk("R9 second rejected", flash_mode_o, 8'h3C);
    chk("R9 err", {7'b0, prot_err_o}, 8'h01);
    wr(A_STAT, 8'h00);

    // R10 back-to-back command writes
    wr(A_CMD, 8'h10); wr(A_CMD, 8'h20); wr(A_CLK, 8'h81);
    chk("R10 double cmd", clk_ctrl_o, 8'h81);
    chk("R10 no err", {7'b0, prot_err_o}, 8'h00);

    // R8 read map
    rd(A_FREE, d); chk("R8 unmapped zero", d, 8'h00);
    rd(12'h802, d); chk("R8 neighbour zero", d, 8'h00);
    check_all("R8 map");

    // pseudo-random run against model
    lfsr = 16'hACE1;
    for (int n = 0; n < 3000; n++) begin
      logic [11:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1: a = A_CMD;
        3'd2:       a = A_CLK;
        3'd3:       a = A_FLASH;
        3'd4:       a = A_STAT;
        3'd5:       a = A_FREE;
        default:    a = 12'hFFF;
      endcase
      if (lfsr[3] && lfsr[4]) idle(a);
      else wr(a, lfsr[15:8]);
      if (n % 10 == 9) check_all("R3 R5 R6 R7 R9 R10 random");
      else begin
        chk("R2 R3 random clk", clk_ctrl_o, m_clk);
        chk("R2 R3 random flash", flash_mode_o, m_flash);
        chk("R4 R5 random err", {7'b0, prot_err_o}, {7'b0, m_err});
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule